// File: doc/BRIEF.md
# Two-Stage Watchdog Timer with Pre-Timeout Interrupt

This block is a bus-programmed watchdog that counts down from one of sixteen power-of-two periods and acts when the count runs out. The first count after enabling uses an initial period index. Every later reload uses the running period index. Software services the watchdog by writing a fixed key to a restart location. Once the enable bit is set, only a hardware reset can clear it.

There are two response modes. In direct mode the first expiry starts a system-reset pulse. In interrupt mode the first expiry raises a pre-timeout interrupt and reloads the counter. A second expiry that arrives while that interrupt is still pending starts the reset pulse. After the pulse the counter freezes until the next hardware reset. Registers are reached through a simple synchronous port: address, write enable, read strobe, write data and registered read data.

Top module: `wdog_top`

## Requirements
- R1: After hardware reset, `irqOut` and `sysRstOut` are low, and the control, period, count and status locations (0x00, 0x04, 0x08, 0x10) all read 0.
- R2: The parameter word at 0x F4 reads 0x00000040, where bit 6 set means fixed power-of-two periods. Unmapped offsets read 0.
- R3: The period register at 0x04 holds the running index in bits [3:0] and the initial index in bits [7:4]. Both read back as written.
- R4: Control bit 0 at 0x00 enables the counter and stays 1 once written. Control bit 1 selects the mode (0 = direct reset, 1 = interrupt first) and reads back as written.
- R5: Enabling loads 2^(BASE_EXP+initial index) into the counter, which reads at 0x08. The counter drops by one per cycle. Expiry happens on the clock edge after the count reads 0, which is load value + 1 edges after the load.
- R6: Writing exactly 0x76 to 0x0C while counting reloads 2^(BASE_EXP+running index) and clears a pending interrupt. Any other value, and any write before enable, has no effect on the count.
- R7: In interrupt mode, an expiry with no interrupt pending sets `irqOut` (0x10 reads 1) and reloads from the running index. An expiry with the interrupt pending starts the reset pulse.
- R8: In direct mode the first expiry starts the reset pulse and `irqOut` stays low.
- R9: A read of 0x14 returns 0 and clears the pending interrupt without reloading the counter.
- R10: `sysRstOut` is high for exactly RST_PULSE cycles. Afterwards the count holds, kicks are ignored and no further pulse occurs until hardware reset.
- R11: Read data appears on `busRdata` on the clock edge that samples `busRe`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous hardware reset |
| busAddr | input | ADDR_W | Byte offset of the accessed register |
| busWe | input | 1 | Write strobe |
| busRe | input | 1 | Read strobe |
| busWdata | input | DATA_W | Write data |
| busRdata | output | DATA_W | Registered read data |
| irqOut | output | 1 | Pre-timeout interrupt, level |
| sysRstOut | output | 1 | System reset pulse |

## Verification
The countdown is run with two different load sources: the initial index right after enable and the running index after a kick. A read of the count at a known edge therefore shows which index was used. Restart writes use the key, a near-miss byte and the key with extra upper bits, so a partial key compare is caught. The interrupt path is driven three ways: serviced by a kick, cleared by a status read, and left alone until the second expiry. This separates clearing from reloading and the first stage from the reset stage. A second run in direct mode confirms that reset follows the first expiry with no interrupt.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int NUM_PERIODS = 16;
  localparam int IDX_W = $clog2(NUM_PERIODS);

  localparam logic [7:0] OFF_CTRL   = 8'h00;
  localparam logic [7:0] OFF_PERIOD = 8'h04;
  localparam logic [7:0] OFF_COUNT  = 8'h08;
  localparam logic [7:0] OFF_KICK   = 8'h0C;
  localparam logic [7:0] OFF_STAT   = 8'h10;
  localparam logic [7:0] OFF_CLR    = 8'h14;
  localparam logic [7:0] OFF_PARAM  = 8'hF4;

  localparam logic [31:0] KICK_KEY   = 32'h0000_0076;
  localparam logic [31:0] PARAM_WORD = 32'h0000_0040;

  // bus events decoded by the register block for the sequencer
  typedef struct packed {
    logic enStart;
    logic kick;
    logic irqRdClr;
  } busEv_t;

  // strobes from the sequencer to the counter datapath
  typedef struct packed {
    logic             load;
    logic [IDX_W-1:0] idx;
    logic             run;
  } cntStrb_t;
endpackage

// File: rtl/wdog_cnt.sv
module wdog_cnt
  import wdog_pkg::*;
#(
  parameter int BASE_EXP = 16,
  parameter int CNT_W    = BASE_EXP + NUM_PERIODS
) (
  input  logic             clk,
  input  logic             rstN,
  input  cntStrb_t         strb,
  output logic [CNT_W-1:0] count,
  output logic             cntZero
);
  logic [CNT_W-1:0] periodTab [NUM_PERIODS];

  for (genvar g = 0; g < NUM_PERIODS; g++) begin : g_period
    assign periodTab[g] = CNT_W'(1) << (BASE_EXP + g);
  end

  assign cntZero = (count == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (strb.load) begin
      count <= periodTab[strb.idx];
    end else if (strb.run && !cntZero) begin
      count <= count - 1'b1;
    end
  end
endmodule

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [DATA_W-1:0] busWdata,
  input  logic              irqPend,
  input  logic [CNT_W-1:0]  count,
  output logic [DATA_W-1:0] busRdata,
  output logic              modeIrq,
  output logic [IDX_W-1:0]  topIdx,
  output logic [IDX_W-1:0]  initIdx,
  output busEv_t            ev
);
  logic                 enBit;
  logic [2*IDX_W-1:0]   periodReg;
  logic [DATA_W-1:0]    rdNext;
  logic                 wrCtrl, wrPeriod, wrKick;

  assign wrCtrl   = busWe && (busAddr == ADDR_W'(OFF_CTRL));
  assign wrPeriod = busWe && (busAddr == ADDR_W'(OFF_PERIOD));
  assign wrKick   = busWe && (busAddr == ADDR_W'(OFF_KICK));

  assign ev.enStart  = wrCtrl && busWdata[0] && !enBit;
  assign ev.kick     = wrKick && (busWdata == DATA_W'(KICK_KEY));
  assign ev.irqRdClr = busRe && (busAddr == ADDR_W'(OFF_CLR));

  assign topIdx  = periodReg[IDX_W-1:0];
  assign initIdx = periodReg[2*IDX_W-1:IDX_W];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enBit     <= 1'b0;
      modeIrq   <= 1'b0;
      periodReg <= '0;
    end else begin
      if (wrCtrl) begin
        enBit   <= enBit | busWdata[0];
        modeIrq <= busWdata[1];
      end
      if (wrPeriod) periodReg <= busWdata[2*IDX_W-1:0];
    end
  end

  always_comb begin
    unique case (busAddr)
      ADDR_W'(OFF_CTRL):   rdNext = DATA_W'({modeIrq, enBit});
      ADDR_W'(OFF_PERIOD): rdNext = DATA_W'(periodReg);
      ADDR_W'(OFF_COUNT):  rdNext = DATA_W'(count);
      ADDR_W'(OFF_STAT):   rdNext = DATA_W'(irqPend);
      ADDR_W'(OFF_PARAM):  rdNext = DATA_W'(PARAM_WORD);
      default:             rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) busRdata <= '0;
    else if (busRe) busRdata <= rdNext;
  end
endmodule

// File: rtl/wdog_seq.sv
module wdog_seq
  import wdog_pkg::*;
#(
  parameter int RST_PULSE = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  busEv_t           ev,
  input  logic             modeIrq,
  input  logic [IDX_W-1:0] topIdx,
  input  logic [IDX_W-1:0] initIdx,
  input  logic             cntZero,
  output cntStrb_t         strb,
  output logic             irqOut,
  output logic             sysRstOut
);
  localparam int PW = $clog2(RST_PULSE + 1);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIRE, S_DONE} seqState_t;

  seqState_t     state;
  logic [PW-1:0] pulseCnt;
  logic          expire, irqSet, irqClr, firstStage;

  assign expire     = (state == S_RUN) && cntZero && !ev.kick;
  assign firstStage = modeIrq && !irqOut;
  assign irqSet     = expire && firstStage;
  assign irqClr     = ev.irqRdClr || (ev.kick && state == S_RUN);
  assign sysRstOut  = (state == S_FIRE);

  always_comb begin
    strb.load = 1'b0;
    strb.idx  = topIdx;
    strb.run  = (state == S_RUN);
    if (state == S_IDLE && ev.enStart) begin
      strb.load = 1'b1;
      strb.idx  = initIdx;
    end else if (state == S_RUN && (ev.kick || irqSet)) begin
      strb.load = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= S_IDLE;
      pulseCnt <= '0;
      irqOut   <= 1'b0;
    end else begin
      if (irqSet) irqOut <= 1'b1;
      else if (irqClr) irqOut <= 1'b0;
      unique case (state)
        S_IDLE: if (ev.enStart) state <= S_RUN;
        S_RUN: begin
          if (expire && !firstStage) begin
            state    <= S_FIRE;
            pulseCnt <= '0;
          end
        end
        S_FIRE: begin
          pulseCnt <= pulseCnt + 1'b1;
          if (pulseCnt == PW'(RST_PULSE - 1)) state <= S_DONE;
        end
        default: state <= S_DONE;
      endcase
    end
  end
endmodule

// File: rtl/wdog_top.sv
module wdog_top
  import wdog_pkg::*;
#(
  parameter int BASE_EXP  = 16,
  parameter int RST_PULSE = 8,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              irqOut,
  output logic              sysRstOut
);
  localparam int CNT_W = BASE_EXP + NUM_PERIODS;

  busEv_t           ev;
  cntStrb_t         strb;
  logic [CNT_W-1:0] curCount;
  logic             cntZero;
  logic             modeIrq;
  logic [IDX_W-1:0] topIdx, initIdx;

  wdog_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
    .busWdata(busWdata), .irqPend(irqOut), .count(curCount), .busRdata(busRdata),
    .modeIrq(modeIrq), .topIdx(topIdx), .initIdx(initIdx), .ev(ev)
  );

  wdog_seq #(.RST_PULSE(RST_PULSE)) u_seq (
    .clk(clk), .rstN(rstN), .ev(ev), .modeIrq(modeIrq), .topIdx(topIdx),
    .initIdx(initIdx), .cntZero(cntZero), .strb(strb), .irqOut(irqOut),
    .sysRstOut(sysRstOut)
  );

  wdog_cnt #(.BASE_EXP(BASE_EXP), .CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rstN(rstN), .strb(strb), .count(curCount), .cntZero(cntZero)
  );
endmodule

// File: rtl/wdog_chk.sv
module wdog_chk
  import wdog_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int CNT_W     = 32,
  parameter int RST_PULSE = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWe,
  input logic              busRe,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic              irqOut,
  input logic              sysRstOut,
  input cntStrb_t          strb,
  input logic [CNT_W-1:0]  curCount,
  input logic              cntZero
);
  logic goodKick, badKick;
  int   hiLen;

  assign goodKick = busWe && busAddr == ADDR_W'(OFF_KICK) && busWdata == DATA_W'(KICK_KEY);
  assign badKick  = busWe && busAddr == ADDR_W'(OFF_KICK) && busWdata != DATA_W'(KICK_KEY);

  always_ff @(posedge clk) begin
    if (!rstN) hiLen <= 0;
    else if (sysRstOut) hiLen <= hiLen + 1;
    else hiLen <= 0;
  end

  // R6: a keyed restart while counting leaves no interrupt pending
  a_r6_kick_clears_irq: assert property (@(posedge clk) disable iff (!rstN)
    (goodKick && strb.run) |=> !irqOut);

  // R6: a wrong key does not disturb the countdown
  a_r6_bad_key_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (badKick && strb.run && !cntZero) |=> curCount == $past(curCount) - 1'b1);

  // R7: the interrupt only rises from an expired count
  a_r7_irq_from_zero: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> $past(cntZero));

  // R10: the reset pulse only starts from an expired count
  a_r10_rst_from_zero: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sysRstOut) |-> $past(cntZero));

  // R10: pulse width
  a_r10_pulse_width: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sysRstOut) |-> hiLen == RST_PULSE);

  // R10: the counter is frozen once the pulse ends
  a_r10_hold_after: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sysRstOut) |=> $stable(curCount));

  // R9: reading the clear location returns zero
  a_r9_clr_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busRe && busAddr == ADDR_W'(OFF_CLR)) |=> busRdata == '0);
endmodule

bind wdog_top wdog_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .RST_PULSE(RST_PULSE)
) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
  .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut),
  .sysRstOut(sysRstOut), .strb(strb), .curCount(curCount), .cntZero(cntZero)
);

// File: tb/sim_wdog_top.sv
module sim_wdog_top;
  localparam int BASE  = 4;
  localparam int PULSE = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0, busRe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic        irqOut, sysRstOut;

  always #2 clk = ~clk;

  wdog_top #(.BASE_EXP(BASE), .RST_PULSE(PULSE)) u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe), .busRe(busRe),
    .busWdata(busWdata), .busRdata(busRdata), .irqOut(irqOut), .sysRstOut(sysRstOut)
  );

  int edgeN = 0;
  always @(posedge clk) edgeN <= edgeN + 1;

  int nChk = 0, nErr = 0;
  int lastWr = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];
  logic        rdTag = 1'b0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard monitor: pops one expected item per completed read
  always @(posedge clk) rdTag <= busRe;
  always @(negedge clk) begin
    if (rdTag && expQ.size() > 0) begin
      logic [31:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      check(t, busRdata, e);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    lastWr = edgeN + 1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    busAddr = a; busRe = 1'b1;
    expQ.push_back(exp); tagQ.push_back(tag);
    @(negedge clk);
    busRe = 1'b0;
  endtask

  // expected count = load value minus cycles elapsed since the load edge
  task automatic rdCnt(input int ld, input int base, input string tag);
    @(negedge clk);
    busAddr = 8'h08; busRe = 1'b1;
    expQ.push_back(32'(ld - (edgeN - base))); tagQ.push_back(tag);
    @(negedge clk);
    busRe = 1'b0;
  endtask

  task automatic waitHigh(input bit useRst, output int at);
    at = -1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if ((useRst ? sysRstOut : irqOut) === 1'b1) begin
        at = edgeN;
        break;
      end
    end
  endtask

  task automatic hwReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChk++; nErr++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end

  initial begin
    int ew, ek, atI, atI2, atI3, atR, w;
    repeat (3) @(negedge clk);
    check("R1 irq", 32'(irqOut), 0);
    check("R1 rst", 32'(sysRstOut), 0);
    rstN = 1'b1;
    rd(8'h00, 0, "R1 ctrl");
    rd(8'h04, 0, "R1 period");
    rd(8'h08, 0, "R1 count");
    rd(8'h10, 0, "R1 stat");
    rd(8'hF4, 32'h40, "R2 R11 param");
    rd(8'h20, 0, "R2 unmapped");

    wr(8'h04, 32'h10);                 // initial idx 1, running idx 0
    rd(8'h04, 32'h10, "R3 readback");
    wr(8'h0C, 32'h76);                 // kick before enable
    rd(8'h08, 0, "R6 kick before enable");

    wr(8'h00, 32'h3);                  // enable, interrupt mode
    ew = lastWr;
    rdCnt(32, ew, "R5 initial load");
    rd(8'h00, 32'h3, "R4 ctrl");
    wr(8'h00, 32'h2);                  // try to clear enable
    rd(8'h00, 32'h3, "R4 sticky enable");
    rdCnt(32, ew, "R5 decrement");
    wr(8'h0C, 32'h75);
    wr(8'h0C, 32'h176);
    rdCnt(32, ew, "R6 bad key");

    wr(8'h0C, 32'h76);
    ek = lastWr;
    rdCnt(16, ek, "R6 reload running idx");
    waitHigh(1'b0, atI);
    check("R5 expiry edge", 32'(atI), 32'(ek + 17));
    rdCnt(16, atI, "R7 reload on first expiry");
    rd(8'h10, 1, "R7 status");

    wr(8'h0C, 32'h76);
    ek = lastWr;
    check("R6 kick clears irq", 32'(irqOut), 0);
    rd(8'h10, 0, "R6 status cleared");

    waitHigh(1'b0, atI2);
    check("R7 second irq edge", 32'(atI2), 32'(ek + 17));
    rd(8'h14, 0, "R9 clear reads zero");
    check("R9 irq cleared", 32'(irqOut), 0);
    rdCnt(16, atI2, "R9 no reload");

    waitHigh(1'b0, atI3);
    check("R9 first stage again", 32'(atI3), 32'(atI2 + 17));
    waitHigh(1'b1, atR);
    check("R7 reset after second expiry", 32'(atR), 32'(atI3 + 17));
    w = 1;
    while (sysRstOut === 1'b1 && w < 100) begin
      @(negedge clk);
      if (sysRstOut === 1'b1) w++;
    end
    check("R10 pulse width", 32'(w), PULSE);
    rd(8'h08, 0, "R10 count held");
    wr(8'h0C, 32'h76);
    rd(8'h08, 0, "R10 kick ignored");
    repeat (40) @(negedge clk);
    check("R10 no second pulse", 32'(sysRstOut), 0);

    hwReset();
    rd(8'h00, 0, "R1 ctrl after reset");
    wr(8'h04, 32'h02);                 // initial idx 0, running idx 2
    wr(8'h00, 32'h1);                  // enable, direct mode
    ew = lastWr;
    waitHigh(1'b1, atR);
    check("R8 direct reset edge", 32'(atR), 32'(ew + 17));
    check("R8 no irq", 32'(irqOut), 0);
    rd(8'h10, 0, "R8 status zero");

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", nErr, nChk);
    $finish;
  end
endmodule